// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a 16-bit up-counting timer behind a small byte-addressed register port. The system clock is divided by a programmable prescaler; each prescaler period advances the counter by one. When the counter counts onto a programmed reference value, a sticky reference flag is set, and if the interrupt-enable mode bit is on, a level interrupt is raised. Software can read and preload the counter, clear flags by writing ones, and choose whether the counter returns to zero after a match or runs on and rolls over.

The register port is a plain control interface and has no handshake. A write is taken on any clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. Edge-capture and output-pin behaviour are not part of this block. The capture register and the mode bits that would drive capture and output are only stored.

Top module: `ptmr_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register offsets are: mode 0x00, reference 0x04, capture 0x08, counter 0x0C, event 0x11 (event flags in bits 1:0). Any other offset reads zero. The capture register reads back what was last written to it.
- R3: Mode layout: bit 0 is enable, bits 2:1 are the clock source, bit 3 is restart-on-match, bit 4 is interrupt enable, and bits 15:8 are the prescale field P. Source 1 gives a ratio of P+1 and source 2 gives (P+1)*16. The counter advances once every ratio cycles, and the first advance lands exactly ratio cycles after the mode write edge.
- R4: The counter holds its value while enable is 0 or while the source is 0 or 3.
- R5: A mode write that changes enable from 1 to 0 clears both mode and reference. A mode write made while enable is already 0 stores the written value.
- R6: A write to the counter offset loads the counter on that edge, and counting resumes from the loaded value.
- R7: Event bit 1 is set on the edge where the counter counts onto the reference value, and it stays set. Event bit 0 is the capture flag and is never set by hardware.
- R8: With restart-on-match set, the counter returns to 0 on the advance after the one that matched. With it clear, the counter wraps from 0xFFFF to 0x0000.
- R9: Writing the event offset clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R10: `irq` is high exactly when mode bit 4 and event bit 1 are both set. It reflects any register write from the cycle after that write.
- R11: Any write to mode or reference restarts the prescaler, so the next advance comes one full ratio after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset for both read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt from the reference flag |

## Verification
Register writes land on the edge that samples `reg_wr`. Read data and `irq` show the written value from the following low clock phase. The bench therefore samples at the falling edge after each write task returns. After a mode write, the counter's k-th advance lands k*ratio edges later, so the sweep reads at ratio-1 and at ratio edges to test both sides of each step. A match flag appears on the same edge as the matching count. A restart-to-zero appears one advance later, and the checks count edges from the enabling write to line up with both.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int EVT_W  = 2;

  localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_REF  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CAP  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 5'h11;

  localparam int MB_EN     = 0;
  localparam int MB_SRC_LO = 1;
  localparam int MB_WRAP   = 3;
  localparam int MB_IRQEN  = 4;
  localparam int MB_PRE_LO = 8;

  localparam int EV_CAP = 0;
  localparam int EV_REF = 1;

  typedef enum logic [1:0] {
    SRC_HALT0 = 2'd0,
    SRC_DIV   = 2'd1,
    SRC_DIV16 = 2'd2,
    SRC_HALT3 = 2'd3
  } src_e;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int PRE_W  = 8,
  parameter int X16_SH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             div16,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int PC_W = PRE_W + X16_SH;

  logic [PC_W:0]   ratio_base;
  logic [PC_W:0]   ratio;
  logic [PC_W:0]   ratio_m1;
  logic [PC_W-1:0] lim;
  logic [PC_W-1:0] pc_q;

  always_comb begin
    ratio_base = {{(X16_SH + 1){1'b0}}, pre} + {{PC_W{1'b0}}, 1'b1};
    ratio      = div16 ? (ratio_base << X16_SH) : ratio_base;
    ratio_m1   = ratio - {{PC_W{1'b0}}, 1'b1};
    lim        = ratio_m1[PC_W-1:0];
  end

  assign tick = run && !restart && (pc_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (restart || !run || tick) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + {{(PC_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             wrap_en,
  input  logic [CNT_W-1:0] ref_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] next_val;

  always_comb begin
    if (wrap_en && (cnt_q == ref_val)) begin
      next_val = '0;
    end else begin
      next_val = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  assign hit = tick && !load && (next_val == ref_val);
  assign cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= next_val;
    end
  end
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              hit,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] mode,
  output logic [DATA_W-1:0] ref_val,
  output logic [EVT_W-1:0]  evt,
  output logic              wr_cnt,
  output logic              wr_timing,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] mode_q, ref_q, cap_q;
  logic [EVT_W-1:0]  evt_q, clr_mask, set_mask;
  logic wr_mode, wr_ref, wr_cap, wr_evt, disabling;

  assign wr_mode   = reg_wr && (reg_addr == OFS_MODE);
  assign wr_ref    = reg_wr && (reg_addr == OFS_REF);
  assign wr_cap    = reg_wr && (reg_addr == OFS_CAP);
  assign wr_cnt    = reg_wr && (reg_addr == OFS_CNT);
  assign wr_evt    = reg_wr && (reg_addr == OFS_EVT);
  assign wr_timing = wr_mode || wr_ref;
  assign disabling = wr_mode && mode_q[MB_EN] && !reg_wdata[MB_EN];

  always_comb begin
    clr_mask = wr_evt ? reg_wdata[EVT_W-1:0] : '0;
    set_mask = '0;
    set_mask[EV_REF] = hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
      evt_q  <= '0;
    end else begin
      if (disabling) begin
        mode_q <= '0;
        ref_q  <= '0;
      end else begin
        if (wr_mode) mode_q <= reg_wdata;
        if (wr_ref)  ref_q  <= reg_wdata;
      end
      if (wr_cap) cap_q <= reg_wdata;
      evt_q <= (evt_q & ~clr_mask) | set_mask;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_MODE: reg_rdata = mode_q;
      OFS_REF:  reg_rdata = ref_q;
      OFS_CAP:  reg_rdata = cap_q;
      OFS_CNT:  reg_rdata = cnt;
      OFS_EVT:  reg_rdata = {{(DATA_W-EVT_W){1'b0}}, evt_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign mode    = mode_q;
  assign ref_val = ref_q;
  assign evt     = evt_q;
  assign irq     = mode_q[MB_IRQEN] && evt_q[EV_REF];
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int PRE_W  = 8,
  parameter int X16_SH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] mode_w, ref_w, cnt_w;
  logic [EVT_W-1:0]  evt_w;
  logic              wr_cnt, wr_timing, tick, hit, run, div16;
  src_e              src;

  assign src   = src_e'(mode_w[MB_SRC_LO +: 2]);
  assign run   = mode_w[MB_EN] && ((src == SRC_DIV) || (src == SRC_DIV16));
  assign div16 = (src == SRC_DIV16);

  ptmr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .hit       (hit),
    .cnt       (cnt_w),
    .mode      (mode_w),
    .ref_val   (ref_w),
    .evt       (evt_w),
    .wr_cnt    (wr_cnt),
    .wr_timing (wr_timing),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  ptmr_prescaler #(.PRE_W(PRE_W), .X16_SH(X16_SH)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (wr_timing),
    .div16   (div16),
    .pre     (mode_w[MB_PRE_LO +: PRE_W]),
    .tick    (tick)
  );

  ptmr_count #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (wr_cnt),
    .load_val (reg_wdata),
    .wrap_en  (mode_w[MB_WRAP]),
    .ref_val  (ref_w),
    .cnt      (cnt_w),
    .hit      (hit)
  );
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
  import ptmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic [DATA_W-1:0] mode_q,
  input logic [DATA_W-1:0] ref_q,
  input logic [EVT_W-1:0]  evt_q,
  input logic [DATA_W-1:0] cnt_q
);
  logic wr_cnt_c, wr_evt_c, wr_mode_c;
  assign wr_cnt_c  = reg_wr && (reg_addr == OFS_CNT);
  assign wr_evt_c  = reg_wr && (reg_addr == OFS_EVT);
  assign wr_mode_c = reg_wr && (reg_addr == OFS_MODE);

  // R4: a disabled timer does not count
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[MB_EN] && !wr_cnt_c) |=> (cnt_q == $past(cnt_q)));

  // R7: reference flag is sticky unless cleared by a write of one
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q[EV_REF] && !(wr_evt_c && reg_wdata[EV_REF])) |=> evt_q[EV_REF]);

  // R8: without a load the counter holds, steps by one, or returns to zero
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt_c |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 16'd1) || (cnt_q == '0)));

  // R10: interrupt only with its enable and the reference flag
  a_r10_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mode_q[MB_IRQEN] && evt_q[EV_REF]));

  // R5: disabling write clears mode and reference
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode_c && mode_q[MB_EN] && !reg_wdata[MB_EN]) |=> ((mode_q == '0) && (ref_q == '0)));

  // R7: capture flag never set by hardware
  a_r7_cap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_q[EV_CAP] |=> !evt_q[EV_CAP]);
endmodule

bind ptmr_top ptmr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .mode_q    (mode_w),
  .ref_q     (ref_w),
  .evt_q     (evt_w),
  .cnt_q     (cnt_w)
);

// File: tb/ptmr_top_test.sv
`timescale 1ns/1ps
module ptmr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  ptmr_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] refv, input logic [15:0] cntv);
    wr(5'h00, 16'h0000);
    wr(5'h04, refv);
    wr(5'h0C, cntv);
  endtask

  initial begin
    logic [15:0] v, held;
    int pl[4] = '{0, 1, 2, 5};
    @(negedge clk);
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    rd(5'h00, v); chk("R1 mode", v, 16'h0);
    rd(5'h04, v); chk("R1 ref", v, 16'h0);
    rd(5'h08, v); chk("R1 cap", v, 16'h0);
    rd(5'h0C, v); chk("R1 cnt", v, 16'h0);
    rd(5'h11, v); chk("R1 evt", v, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2 capture storage and unmapped reads
    wr(5'h08, 16'hA5C3);
    rd(5'h08, v); chk("R2 cap", v, 16'hA5C3);
    rd(5'h02, v); chk("R2 unmapped 02", v, 16'h0);
    rd(5'h10, v); chk("R2 unmapped 10", v, 16'h0);

    // R3 ratio sweep
    foreach (pl[i]) begin
      for (int si = 1; si <= 2; si++) begin
        int r;
        r = (pl[i] + 1) * ((si == 2) ? 16 : 1);
        setup(16'hFFFF, 16'h0000);
        wr(5'h00, 16'(pl[i] << 8) | 16'(si << 1) | 16'h1);
        cyc(r - 1);     rd(5'h0C, v); chk("R3 before 1st", v, 16'd0);
        cyc(1);         rd(5'h0C, v); chk("R3 1st", v, 16'd1);
        cyc(3 * r - 1); rd(5'h0C, v); chk("R3 before 4th", v, 16'd3);
        cyc(1);         rd(5'h0C, v); chk("R3 4th", v, 16'd4);
      end
    end

    // R5 disable clears, R4 hold while disabled
    wr(5'h04, 16'h1234);
    wr(5'h00, 16'h0000);
    rd(5'h00, v); chk("R5 mode cleared", v, 16'h0);
    rd(5'h04, v); chk("R5 ref cleared", v, 16'h0);
    wr(5'h00, 16'h0032);
    rd(5'h00, v); chk("R5 stored while off", v, 16'h0032);
    rd(5'h0C, held);
    cyc(10);
    rd(5'h0C, v); chk("R4 hold disabled", v, held);

    // R7 R8 R10 restart-on-match
    setup(16'd3, 16'd0);
    wr(5'h00, 16'h001B);
    cyc(2);
    rd(5'h0C, v); chk("R8 count 2", v, 16'd2);
    rd(5'h11, v); chk("R7 no flag yet", v, 16'h0);
    chk("R10 irq low", {15'b0, irq}, 16'h0);
    cyc(1);
    rd(5'h0C, v); chk("R7 count at ref", v, 16'd3);
    rd(5'h11, v); chk("R7 flag set", v, 16'h2);
    chk("R10 irq high", {15'b0, irq}, 16'h1);
    cyc(1);
    rd(5'h0C, v); chk("R8 wrap to zero", v, 16'd0);

    // R4 source 0 holds, R9 write-one-to-clear, R10 follows write
    wr(5'h00, 16'h0011);
    chk("R10 irq after mode write", {15'b0, irq}, 16'h1);
    rd(5'h0C, held);
    cyc(8);
    rd(5'h0C, v); chk("R4 hold src0", v, held);
    wr(5'h00, 16'h0017);
    rd(5'h0C, held);
    cyc(8);
    rd(5'h0C, v); chk("R4 hold src3", v, held);
    wr(5'h11, 16'h0001);
    rd(5'h11, v); chk("R9 other bit kept", v, 16'h2);
    wr(5'h11, 16'h0002);
    rd(5'h11, v); chk("R9 flag cleared", v, 16'h0);
    chk("R10 irq cleared", {15'b0, irq}, 16'h0);

    // R8 free-run rollover, R10 irq masked
    setup(16'h0001, 16'hFFFE);
    wr(5'h00, 16'h0003);
    cyc(1); rd(5'h0C, v); chk("R8 ffff", v, 16'hFFFF);
    cyc(1); rd(5'h0C, v); chk("R8 rollover", v, 16'h0000);
    rd(5'h11, v); chk("R7 no early flag", v, 16'h0);
    cyc(1); rd(5'h0C, v); chk("R8 after roll", v, 16'h0001);
    rd(5'h11, v); chk("R7 flag after roll", v, 16'h2);
    chk("R10 irq masked", {15'b0, irq}, 16'h0);

    // R6 counter load while running
    wr(5'h0C, 16'h0100);
    rd(5'h0C, v); chk("R6 loaded", v, 16'h0100);
    cyc(2);
    rd(5'h0C, v); chk("R6 resumes", v, 16'h0102);

    // R11 mode rewrite restarts prescaler
    setup(16'hFFFF, 16'h0000);
    wr(5'h00, 16'h0303);
    cyc(2);
    wr(5'h00, 16'h0303);
    rd(5'h0C, v); chk("R11 no step yet", v, 16'd0);
    cyc(3); rd(5'h0C, v); chk("R11 before step", v, 16'd0);
    cyc(1); rd(5'h0C, v); chk("R11 step", v, 16'd1);
    cyc(2);
    wr(5'h04, 16'hFFFF);
    cyc(3); rd(5'h0C, v); chk("R11 ref write delays", v, 16'd1);
    cyc(1); rd(5'h0C, v); chk("R11 ref write step", v, 16'd2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule